// File: doc/BRIEF.md
# OTP Fuse Controller Register Front-End

This block is the software-visible face of a one-time-programmable fuse controller. It decodes a simple single-cycle register bus and turns register writes into three kinds of command for a separate timing sequencer: burn one fuse word, read a run of fuse words, or refresh every shadow register from the fuses. While a command is out, the block holds a busy flag, refuses further writes, and waits for the sequencer to signal completion and report its outcome.

Burning is protected by a 16-bit key that software must place in the control register before each burn. The key is wiped after every burn attempt, so each burn needs a fresh key. The control register is reachable through a plain address and through two alias addresses that OR bits in or clear bits. Completion flags collect in a sticky status register with its own clear alias. Words returned by a read land in a small bank of read-data registers that keep their contents until the next read.

Top module: `otp_fuse_regs`

## Requirements
- R1: A write to the data register (address 3) while the control key field (bits 31:16) holds 0x3E77 issues one burn command (cmd_op_o = 1) carrying the fuse address from control bits 7:0, the written data, and the word-lock bit from control bit 9.
- R2: Control sits at address 0 (write replaces its fields), its OR alias at address 1 and its clear alias at address 2; fuse address, reload bit, word-lock bit and key field can all be changed through any of the three.
- R3: busy_o, also visible as control bit 11, rises in the cycle after a command is issued and stays high until the sequencer pulses seq_done_i; each accepted operation produces exactly one cmd_valid_o pulse.
- R4: Any bus write made while busy is dropped and sets the error flag at control bit 10; the flag stays set until an idle write to the clear alias with bit 10 set.
- R5: A data-register write with any key other than 0x3E77 issues no command and sets the error flag.
- R6: Changing the reload bit (control bit 8) from 0 to 1 issues a reload command (cmd_op_o = 3); the bit reads 1 while the reload runs and returns to 0 when it completes.
- R7: Writing the read-control register (address 4) with bit 0 set issues a read command (cmd_op_o = 2) whose count is bits 2:1 (words minus one) and whose address is control bits 7:0. Word i lands in the read-data register at address 8+i. Bit 0 clears when the read completes.
- R8: The read-data registers change only while a read is running and keep their values across later burns and reloads.
- R9: The status register (address 5) holds burn-fail (bit 0), word-locked (bit 1) and uncorrectable-read (bit 2). Each is set from the sequencer's outcome at completion, is sticky, and is cleared only by writing 1 to its bit at the status clear alias (address 6).
- R10: The key field and the word-lock bit are cleared after every idle data-register write, whether the key was right or wrong.
- R11: After reset, all registers read zero, busy_o is low and no command is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 4 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from bus_addr_i |
| busy_o | output | 1 | Operation in flight |
| cmd_valid_o | output | 1 | One-cycle command pulse to the sequencer |
| cmd_op_o | output | 2 | 1 burn, 2 read, 3 reload |
| cmd_addr_o | output | 8 | Fuse word address |
| cmd_data_o | output | 32 | Data to burn |
| cmd_lock_o | output | 1 | Lock the target word after burning |
| cmd_cnt_o | output | 2 | Read word count minus one |
| seq_done_i | input | 1 | Sequencer completion pulse |
| seq_fail_i | input | 1 | Burn failed, valid with seq_done_i |
| seq_locked_i | input | 1 | Target word was locked, valid with seq_done_i |
| seq_ded_i | input | 1 | Uncorrectable read error, valid with seq_done_i |
| seq_rd_valid_i | input | 1 | Read word strobe |
| seq_rd_idx_i | input | 2 | Read word index |
| seq_rd_data_i | input | 32 | Read word data |

## Verification
The bench targets the key guard. A design that checked the key a cycle late, or forgot to wipe it, would allow a second burn with no fresh key, and the wrong-key case would then issue a command that the scoreboard flags. Writes landing mid-operation are probed through an address change that must not appear and an error flag that must appear. A design that forgot to block those writes would show the new address. The self-clearing reload and read-go bits are read back both during and after the operation, and a design that never cleared them would read 1 afterwards. A locked-word burn, a failing burn and a read that crosses a bad word exercise the sticky status bits and their per-bit clearing. A design that cleared status as a whole, or overwrote the read bank during a burn, would show mismatched values.

// File: rtl/otp_fuse_pkg.sv
package otp_fuse_pkg;
  localparam int DW    = 32;
  localparam int KEY_W = 16;
  localparam int RA_W  = 4;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'h3E77;

  localparam logic [RA_W-1:0] RA_CTRL  = 4'd0;
  localparam logic [RA_W-1:0] RA_CSET  = 4'd1;
  localparam logic [RA_W-1:0] RA_CCLR  = 4'd2;
  localparam logic [RA_W-1:0] RA_DATA  = 4'd3;
  localparam logic [RA_W-1:0] RA_RDCTL = 4'd4;
  localparam logic [RA_W-1:0] RA_STAT  = 4'd5;
  localparam logic [RA_W-1:0] RA_SCLR  = 4'd6;
  localparam logic [RA_W-1:0] RA_RBUF  = 4'd8;

  localparam int B_RELOAD = 8;
  localparam int B_WLOCK  = 9;
  localparam int B_ERR    = 10;
  localparam int B_BUSY   = 11;
  localparam int B_KEY    = 16;

  localparam int NFLAG    = 3;

  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_PROG   = 2'd1,
    OP_READ   = 2'd2,
    OP_RELOAD = 2'd3
  } op_e;
endpackage

// File: rtl/otp_cmd_ctrl.sv
module otp_cmd_ctrl
  import otp_fuse_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [RA_W-1:0]   waddr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              seq_done_i,
  output logic              acc_o,
  output logic [DW-1:0]     ctrl_o,
  output logic              rd_go_o,
  output logic [CNT_W-1:0]  rd_cnt_o,
  output logic              busy_o,
  output logic              cmd_valid_o,
  output op_e               cmd_op_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DW-1:0]     cmd_data_o,
  output logic              cmd_lock_o,
  output logic [CNT_W-1:0]  cmd_cnt_o
);
  logic [ADDR_W-1:0] fa_q;
  logic              reload_q, wlock_q, err_q, busy_q, rd_go_q;
  logic [KEY_W-1:0]  key_q;
  logic [CNT_W-1:0]  rd_cnt_q;
  logic              cmd_valid_q, cmd_lock_q;
  op_e               cmd_op_q;
  logic [ADDR_W-1:0] cmd_addr_q;
  logic [DW-1:0]     cmd_data_q;
  logic [CNT_W-1:0]  cmd_cnt_q;

  logic [DW-1:0] cur, nxt;
  logic acc, rej, is_ctrl, prog_try, key_ok, prog_go, rd_start, rl_start, err_clr, start;

  assign acc      = wr_i & ~busy_q;
  assign rej      = wr_i & busy_q;
  assign is_ctrl  = (waddr_i == RA_CTRL) | (waddr_i == RA_CSET) | (waddr_i == RA_CCLR);
  assign prog_try = acc & (waddr_i == RA_DATA);
  assign key_ok   = (key_q == UNLOCK_KEY);
  assign prog_go  = prog_try & key_ok;
  assign rd_start = acc & (waddr_i == RA_RDCTL) & wdata_i[0];
  assign err_clr  = acc & (waddr_i == RA_CCLR) & wdata_i[B_ERR];

  always_comb begin
    cur = '0;
    cur[ADDR_W-1:0]    = fa_q;
    cur[B_RELOAD]      = reload_q;
    cur[B_WLOCK]       = wlock_q;
    cur[B_KEY+:KEY_W]  = key_q;
  end

  always_comb begin
    case (waddr_i)
      RA_CTRL: nxt = wdata_i;
      RA_CSET: nxt = cur | wdata_i;
      RA_CCLR: nxt = cur & ~wdata_i;
      default: nxt = cur;
    endcase
  end

  assign rl_start = acc & is_ctrl & nxt[B_RELOAD] & ~reload_q;
  assign start    = rl_start | rd_start | prog_go;

  // control fields
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fa_q     <= '0;
      reload_q <= 1'b0;
      wlock_q  <= 1'b0;
      key_q    <= '0;
    end else begin
      if (acc & is_ctrl) begin
        fa_q     <= nxt[ADDR_W-1:0];
        reload_q <= nxt[B_RELOAD];
        wlock_q  <= nxt[B_WLOCK];
        key_q    <= nxt[B_KEY+:KEY_W];
      end
      if (prog_try) begin
        key_q   <= '0;
        wlock_q <= 1'b0;
      end
      if (busy_q & seq_done_i) reload_q <= 1'b0;
    end
  end

  // read control
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_go_q  <= 1'b0;
      rd_cnt_q <= '0;
    end else if (acc & (waddr_i == RA_RDCTL)) begin
      rd_go_q  <= wdata_i[0];
      rd_cnt_q <= wdata_i[CNT_W:1];
    end else if (busy_q & seq_done_i) begin
      rd_go_q  <= 1'b0;
    end
  end

  // busy and sticky access error
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (start)           busy_q <= 1'b1;
      else if (seq_done_i) busy_q <= 1'b0;
      if (rej | (prog_try & ~key_ok)) err_q <= 1'b1;
      else if (err_clr)               err_q <= 1'b0;
    end
  end

  // command issue
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_q <= 1'b0;
      cmd_op_q    <= OP_IDLE;
      cmd_addr_q  <= '0;
      cmd_data_q  <= '0;
      cmd_lock_q  <= 1'b0;
      cmd_cnt_q   <= '0;
    end else begin
      cmd_valid_q <= start;
      if (start) begin
        cmd_op_q   <= rl_start ? OP_RELOAD : (rd_start ? OP_READ : OP_PROG);
        cmd_addr_q <= is_ctrl ? nxt[ADDR_W-1:0] : fa_q;
        cmd_data_q <= prog_go ? wdata_i : '0;
        cmd_lock_q <= prog_go & wlock_q;
        cmd_cnt_q  <= rd_start ? wdata_i[CNT_W:1] : '0;
      end
    end
  end

  always_comb begin
    ctrl_o         = cur;
    ctrl_o[B_ERR]  = err_q;
    ctrl_o[B_BUSY] = busy_q;
  end

  assign acc_o       = acc;
  assign rd_go_o     = rd_go_q;
  assign rd_cnt_o    = rd_cnt_q;
  assign busy_o      = busy_q;
  assign cmd_valid_o = cmd_valid_q;
  assign cmd_op_o    = cmd_op_q;
  assign cmd_addr_o  = cmd_addr_q;
  assign cmd_data_o  = cmd_data_q;
  assign cmd_lock_o  = cmd_lock_q;
  assign cmd_cnt_o   = cmd_cnt_q;

  a_r5_bad_key_no_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !busy_q && waddr_i == RA_DATA && key_q != UNLOCK_KEY) |=> (!cmd_valid_q && err_q));
  a_r4_reject_sets_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && busy_q) |=> (err_q && !cmd_valid_q));
  a_r3_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !seq_done_i) |=> busy_q);
  a_r3_cmd_then_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_q |-> busy_q);
  a_r10_key_wiped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !busy_q && waddr_i == RA_DATA) |=> (key_q == '0 && !wlock_q));
  a_r6_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && seq_done_i) |=> (!reload_q && !rd_go_q));
  a_r4_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !(wr_i && !busy_q && waddr_i == RA_CCLR && wdata_i[B_ERR])) |=> err_q);
endmodule

// File: rtl/otp_status.sv
module otp_status
  import otp_fuse_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_en_i,
  input  logic [NFLAG-1:0] set_i,
  input  logic             clr_en_i,
  input  logic [NFLAG-1:0] clr_i,
  output logic [NFLAG-1:0] flags_o
);
  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      flag_q <= 1'b0;
      else if (set_en_i && set_i[g])    flag_q <= 1'b1;
      else if (clr_en_i && clr_i[g])    flag_q <= 1'b0;
    end
    assign flags_o[g] = flag_q;

    a_r9_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q && !(clr_en_i && clr_i[g])) |=> flag_q);
  end
endmodule

// File: rtl/otp_rd_buf.sv
module otp_rd_buf
  import otp_fuse_pkg::*;
#(
  parameter int WORDS = 4,
  parameter int CNT_W = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      busy_i,
  input  logic                      we_i,
  input  logic [CNT_W-1:0]          idx_i,
  input  logic [DW-1:0]             data_i,
  output logic [WORDS-1:0][DW-1:0]  words_o
);
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        word_q <= '0;
      else if (we_i && busy_i && idx_i == CNT_W'(g))      word_q <= data_i;
    end
    assign words_o[g] = word_q;
  end

  a_r8_fill_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> busy_i);
endmodule

// File: rtl/otp_fuse_regs.sv
module otp_fuse_regs
  import otp_fuse_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int RD_WORDS = 4,
  parameter int CNT_W    = (RD_WORDS > 1) ? $clog2(RD_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [3:0]        bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              busy_o,
  output logic              cmd_valid_o,
  output logic [1:0]        cmd_op_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [31:0]       cmd_data_o,
  output logic              cmd_lock_o,
  output logic [CNT_W-1:0]  cmd_cnt_o,
  input  logic              seq_done_i,
  input  logic              seq_fail_i,
  input  logic              seq_locked_i,
  input  logic              seq_ded_i,
  input  logic              seq_rd_valid_i,
  input  logic [CNT_W-1:0]  seq_rd_idx_i,
  input  logic [31:0]       seq_rd_data_i
);
  logic                          wr, acc, busy, rd_go;
  logic [DW-1:0]                 ctrl;
  logic [CNT_W-1:0]              rd_cnt;
  logic [NFLAG-1:0]              flags;
  logic [RD_WORDS-1:0][DW-1:0]   words;
  op_e                           cmd_op;

  assign wr = bus_req_i & bus_we_i;

  otp_cmd_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr),
    .waddr_i     (bus_addr_i),
    .wdata_i     (bus_wdata_i),
    .seq_done_i  (seq_done_i),
    .acc_o       (acc),
    .ctrl_o      (ctrl),
    .rd_go_o     (rd_go),
    .rd_cnt_o    (rd_cnt),
    .busy_o      (busy),
    .cmd_valid_o (cmd_valid_o),
    .cmd_op_o    (cmd_op),
    .cmd_addr_o  (cmd_addr_o),
    .cmd_data_o  (cmd_data_o),
    .cmd_lock_o  (cmd_lock_o),
    .cmd_cnt_o   (cmd_cnt_o)
  );

  otp_status u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_en_i (busy & seq_done_i),
    .set_i    ({seq_ded_i, seq_locked_i, seq_fail_i}),
    .clr_en_i (acc & (bus_addr_i == RA_SCLR)),
    .clr_i    (bus_wdata_i[NFLAG-1:0]),
    .flags_o  (flags)
  );

  otp_rd_buf #(.WORDS(RD_WORDS), .CNT_W(CNT_W)) u_rdbuf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .busy_i  (busy),
    .we_i    (seq_rd_valid_i),
    .idx_i   (seq_rd_idx_i),
    .data_i  (seq_rd_data_i),
    .words_o (words)
  );

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      RA_CTRL, RA_CSET, RA_CCLR: bus_rdata_o = ctrl;
      RA_RDCTL: begin
        bus_rdata_o[0]       = rd_go;
        bus_rdata_o[CNT_W:1] = rd_cnt;
      end
      RA_STAT: bus_rdata_o[NFLAG-1:0] = flags;
      default: ;
    endcase
    for (int i = 0; i < RD_WORDS; i++)
      if (int'(bus_addr_i) == int'(RA_RBUF) + i) bus_rdata_o = words[i];
  end

  assign busy_o   = busy;
  assign cmd_op_o = cmd_op;

  a_r11_idle_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!busy && !cmd_valid_o));
  a_r3_no_done_when_idle_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);
endmodule

// File: tb/tb_otp_fuse_regs.sv
module tb_otp_fuse_regs;
  import otp_fuse_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        bus_req, bus_we;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        busy_o, cmd_valid_o, cmd_lock_o;
  logic [1:0]  cmd_op_o, cmd_cnt_o;
  logic [7:0]  cmd_addr_o;
  logic [31:0] cmd_data_o;
  logic        seq_done, seq_fail, seq_locked, seq_ded, seq_rd_valid;
  logic [1:0]  seq_rd_idx;
  logic [31:0] seq_rd_data;

  int checks = 0;
  int failures = 0;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  a;
    logic [31:0] d;
    logic        lk;
    logic [1:0]  c;
  } exp_t;
  exp_t expq[$];

  logic [31:0] fuse [256];
  logic        lockb [256];

  otp_fuse_regs dut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_req_i(bus_req), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .busy_o(busy_o), .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o),
    .cmd_addr_o(cmd_addr_o), .cmd_data_o(cmd_data_o), .cmd_lock_o(cmd_lock_o),
    .cmd_cnt_o(cmd_cnt_o),
    .seq_done_i(seq_done), .seq_fail_i(seq_fail), .seq_locked_i(seq_locked),
    .seq_ded_i(seq_ded), .seq_rd_valid_i(seq_rd_valid), .seq_rd_idx_i(seq_rd_idx),
    .seq_rd_data_i(seq_rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check_eq(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic expect_reg(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_rd(a, v);
    check_eq(tag, v, exp);
  endtask

  task automatic push_cmd(input logic [1:0] op, input logic [7:0] a, input logic [31:0] d,
                          input logic lk, input logic [1:0] c);
    exp_t e;
    e.op = op; e.a = a; e.d = d; e.lk = lk; e.c = c;
    expq.push_back(e);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy_o) @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && cmd_valid_o) begin
        checks++;
        if (expq.size() == 0) begin
          failures++;
          $display("FAIL R3 unexpected command got op=%0d addr=%02h exp=none", cmd_op_o, cmd_addr_o);
        end else begin
          exp_t e;
          e = expq.pop_front();
          if (cmd_op_o !== e.op || cmd_addr_o !== e.a || cmd_data_o !== e.d ||
              cmd_lock_o !== e.lk || cmd_cnt_o !== e.c) begin
            failures++;
            $display("FAIL R1/R7 command got op=%0d a=%02h d=%08h lk=%0b c=%0d exp op=%0d a=%02h d=%08h lk=%0b c=%0d",
                     cmd_op_o, cmd_addr_o, cmd_data_o, cmd_lock_o, cmd_cnt_o,
                     e.op, e.a, e.d, e.lk, e.c);
          end
        end
      end
    end
  end

  // behavioural sequencer and fuse array
  initial begin
    seq_done = 0; seq_fail = 0; seq_locked = 0; seq_ded = 0;
    seq_rd_valid = 0; seq_rd_idx = '0; seq_rd_data = '0;
    forever begin
      @(negedge clk);
      if (rst_n && cmd_valid_o) begin
        logic [1:0]  op;
        logic [7:0]  a;
        logic [31:0] d;
        logic        lk, ded, fl, lkd;
        logic [1:0]  c;
        op = cmd_op_o; a = cmd_addr_o; d = cmd_data_o; lk = cmd_lock_o; c = cmd_cnt_o;
        ded = 0; fl = 0; lkd = 0;
        repeat (3) @(negedge clk);
        if (op == 2'(OP_READ)) begin
          for (int i = 0; i <= int'(c); i++) begin
            logic [7:0] fa;
            fa = a + 8'(i);
            seq_rd_valid = 1; seq_rd_idx = 2'(i); seq_rd_data = fuse[fa];
            if (fa == 8'hFE) ded = 1;
            @(negedge clk);
          end
          seq_rd_valid = 0;
        end else if (op == 2'(OP_PROG)) begin
          if (lockb[a]) lkd = 1;
          else if (a == 8'hFF) fl = 1;
          else begin
            fuse[a] = fuse[a] | d;
            if (lk) lockb[a] = 1;
          end
        end
        seq_done = 1; seq_fail = fl; seq_locked = lkd; seq_ded = ded;
        @(negedge clk);
        seq_done = 0; seq_fail = 0; seq_locked = 0; seq_ded = 0;
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired got=hang exp=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin fuse[i] = '0; lockb[i] = 0; end
    fuse[6] = 32'hCAFE_0006; fuse[8'hFD] = 32'h11; fuse[8'hFE] = 32'h22;
    bus_req = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R11 reset state
    expect_reg("R11 ctrl reset", RA_CTRL, 32'h0);
    expect_reg("R11 status reset", RA_STAT, 32'h0);
    expect_reg("R11 rdctl reset", RA_RDCTL, 32'h0);
    check_eq("R11 busy reset", {31'b0, busy_o}, 32'h0);

    // R2 aliases
    bus_wr(RA_CTRL, 32'h12);
    bus_wr(RA_CSET, 32'h21);
    expect_reg("R2 set alias", RA_CTRL, 32'h33);
    bus_wr(RA_CCLR, 32'h03);
    expect_reg("R2 clr alias", RA_CTRL, 32'h30);

    // R1 R3 R10 valid burn
    bus_wr(RA_CTRL, 32'h3E77_0005);
    push_cmd(2'(OP_PROG), 8'h05, 32'hA5A5, 1'b0, 2'd0);
    bus_wr(RA_DATA, 32'hA5A5);
    check_eq("R3 busy after burn", {31'b0, busy_o}, 32'h1);
    expect_reg("R10 key wiped, R3 busy bit", RA_CTRL, 32'h0000_0805);
    wait_idle();
    check_eq("R3 busy drops", {31'b0, busy_o}, 32'h0);

    // R5 wrong key
    bus_wr(RA_CTRL, 32'h1234_0006);
    bus_wr(RA_DATA, 32'h1);
    repeat (5) @(negedge clk);
    check_eq("R5 no busy on bad key", {31'b0, busy_o}, 32'h0);
    expect_reg("R5 err set, R10 key wiped", RA_CTRL, 32'h0000_0406);
    bus_wr(RA_CCLR, 32'h400);
    expect_reg("R4 err cleared", RA_CTRL, 32'h0000_0006);

    // R4 write while busy
    bus_wr(RA_CTRL, 32'h3E77_0007);
    push_cmd(2'(OP_PROG), 8'h07, 32'h0F, 1'b0, 2'd0);
    bus_wr(RA_DATA, 32'h0F);
    bus_wr(RA_CSET, 32'h20);
    wait_idle();
    expect_reg("R4 write dropped, err set", RA_CTRL, 32'h0000_0407);
    bus_wr(RA_CCLR, 32'h400);

    // R6 reload
    push_cmd(2'(OP_RELOAD), 8'h07, 32'h0, 1'b0, 2'd0);
    bus_wr(RA_CSET, 32'h100);
    expect_reg("R6 reload bit while busy", RA_CTRL, 32'h0000_0907);
    wait_idle();
    expect_reg("R6 reload self clears", RA_CTRL, 32'h0000_0007);

    // R7 multi-word read
    bus_wr(RA_CTRL, 32'h5);
    push_cmd(2'(OP_READ), 8'h05, 32'h0, 1'b0, 2'd2);
    bus_wr(RA_RDCTL, 32'h5);
    expect_reg("R7 go bit while busy", RA_RDCTL, 32'h5);
    wait_idle();
    expect_reg("R7 word0", 4'd8, 32'hA5A5);
    expect_reg("R7 word1", 4'd9, 32'hCAFE_0006);
    expect_reg("R7 word2", 4'd10, 32'h0F);
    expect_reg("R7 go self clears", RA_RDCTL, 32'h4);

    // R1 burn with word lock, R8 buffer stable
    bus_wr(RA_CTRL, 32'h3E77_0209);
    push_cmd(2'(OP_PROG), 8'h09, 32'h33, 1'b1, 2'd0);
    bus_wr(RA_DATA, 32'h33);
    wait_idle();
    expect_reg("R8 buffer stable over burn", 4'd8, 32'hA5A5);
    expect_reg("R10 wordlock wiped", RA_CTRL, 32'h0000_0009);

    // R9 locked word
    bus_wr(RA_CTRL, 32'h3E77_0009);
    push_cmd(2'(OP_PROG), 8'h09, 32'hC0, 1'b0, 2'd0);
    bus_wr(RA_DATA, 32'hC0);
    wait_idle();
    expect_reg("R9 locked flag", RA_STAT, 32'h2);
    push_cmd(2'(OP_READ), 8'h09, 32'h0, 1'b0, 2'd0);
    bus_wr(RA_RDCTL, 32'h1);
    wait_idle();
    expect_reg("R9 locked word unchanged", 4'd8, 32'h33);

    // R9 burn fail and per-bit clear
    bus_wr(RA_CTRL, 32'h3E77_00FF);
    push_cmd(2'(OP_PROG), 8'hFF, 32'h1, 1'b0, 2'd0);
    bus_wr(RA_DATA, 32'h1);
    wait_idle();
    expect_reg("R9 fail and locked", RA_STAT, 32'h3);
    bus_wr(RA_SCLR, 32'h1);
    expect_reg("R9 clear fail only", RA_STAT, 32'h2);
    bus_wr(RA_SCLR, 32'h2);
    expect_reg("R9 clear locked", RA_STAT, 32'h0);

    // R9 R7 uncorrectable read
    bus_wr(RA_CTRL, 32'hFD);
    push_cmd(2'(OP_READ), 8'hFD, 32'h0, 1'b0, 2'd1);
    bus_wr(RA_RDCTL, 32'h3);
    wait_idle();
    expect_reg("R9 ded flag", RA_STAT, 32'h4);
    expect_reg("R7 word0 at FD", 4'd8, 32'h11);
    expect_reg("R7 word1 at FE", 4'd9, 32'h22);
    expect_reg("R8 word2 untouched", 4'd10, 32'h0F);

    repeat (5) @(negedge clk);
    check_eq("R3 all commands seen", 32'(expq.size()), 32'h0);
    finish_run();
  end
endmodule